// File: doc/BRIEF.md
# Coefficient Dequantizer and Scan Reorder Stage

This stage sits between an entropy decoder and an inverse transform in an image decompression pipeline. It takes the 64 quantized coefficients of one 8x8 block. They arrive in zigzag scan order over a valid/ready stream. Each coefficient is scaled by the matching entry of one of several loaded quantization tables. The scaled value is stored at its row-major position. Once a block is complete, the stage streams it out in natural order, from position 0 to position 63.

A downscale mode serves previews that are one eighth of full size in each direction. In this mode the inverse transform is skipped. Each block produces one 8-bit pixel, computed from the dequantized DC term and shifted back into the unsigned sample range. Storage is double-buffered, so one block can be read out while the next one is written.

Top module: `dqz_reorder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every table entry holds the value 1.
- R2: Each accepted coefficient at zigzag index k is multiplied by entry k of the selected table. The signed coefficient is taken times the unsigned entry. The table is chosen by `tab_sel` as sampled with the block's first coefficient (k = 0). Later changes to `tab_sel` within the same block have no effect.
- R3: In normal mode, output word n of a block is the product whose zigzag index maps to row-major position n = 8*row + col. The scan starts at (0,0) and moves to (0,1). It then runs along alternating anti-diagonals, so zigzag indices 0..5 map to positions 0, 1, 8, 16, 9, 2.
- R4: Products beyond the 16-bit signed range are clamped to 32767 or -32768.
- R5: When `qt_we` is high, entry `qt_idx` (a zigzag index) of table `qt_tab` is written with `qt_val` at the clock edge. Four tables are provided.
- R6: In downscale mode, a block yields exactly one output word. Its value is `out_data` = clamp(floor(d/8) + 128, 0, 255), zero-extended, where d is the clamped dequantized DC. `out_last` is 1 on that word.
- R7: In normal mode, a block yields exactly 64 words, and `out_last` is 1 only on the 64th.
- R8: Two complete blocks can be accepted while the output is stalled. Input for a third block is refused (`in_ready` is 0) until the first block has been fully read out.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R10: The mode input `scale_en` is sampled with the block's first coefficient. Later changes within the block do not alter the block's output format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient present |
| in_ready | output | 1 | Stage can accept a coefficient |
| in_coef | input | 11 | Signed quantized coefficient, zigzag order |
| tab_sel | input | 2 | Table used for the block starting now |
| scale_en | input | 1 | Downscale mode for the block starting now |
| qt_we | input | 1 | Table write strobe |
| qt_tab | input | 2 | Table written |
| qt_idx | input | 6 | Zigzag index of the entry written |
| qt_val | input | 8 | Unsigned table entry |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Signed coefficient, or a pixel in the low 8 bits |
| out_last | output | 1 | Final word of a block |

## Verification
Three kinds of coefficient pattern exercise the reordering and scaling. A signed ramp read through a table with a non-uniform period exposes any misplaced position or misindexed table entry. A ramp through the identity reset table separates a multiplier fault from a mapping fault. Extreme values of ±1023 and -1024 against an entry of 255 probe both clamps. The downscale DC cases cover a small negative DC, which separates floor division from truncation, as well as both pixel clamps. The tests also include a stalled pair of blocks and switches of mode and table in the middle of a block.

// File: rtl/dqz_pkg.sv
package dqz_pkg;
   localparam int BLK_N = 64;
   localparam int IDX_W = 6;

   // row-major position of zigzag index k, walked along anti-diagonals
   function automatic logic [IDX_W-1:0] zz2nat(input int k);
      int n;
      logic [IDX_W-1:0] r;
      n = 0;
      r = '0;
      for (int s = 0; s < 15; s++) begin
         int lo;
         int hi;
         lo = (s > 7) ? s - 7 : 0;
         hi = (s < 7) ? s : 7;
         for (int t = 0; t <= hi - lo; t++) begin
            int row;
            row = (s % 2 == 0) ? hi - t : lo + t;
            if (n == k) r = IDX_W'(row * 8 + (s - row));
            n++;
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/dqz_qtab.sv
module dqz_qtab #(
   parameter int NTAB   = 4,
   parameter int TSEL_W = 2,
   parameter int QT_W   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [TSEL_W-1:0]             wtab,
   input  logic [dqz_pkg::IDX_W-1:0]     widx,
   input  logic [QT_W-1:0]               wval,
   input  logic [TSEL_W-1:0]             rtab,
   input  logic [dqz_pkg::IDX_W-1:0]     ridx,
   output logic [QT_W-1:0]               rval
);
   logic [QT_W-1:0] tab [NTAB][dqz_pkg::BLK_N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < NTAB; t++)
            for (int i = 0; i < dqz_pkg::BLK_N; i++)
               tab[t][i] <= QT_W'(1);
      end else if (we && int'(wtab) < NTAB) begin
         tab[wtab][widx] <= wval;
      end
   end

   assign rval = (int'(rtab) < NTAB) ? tab[rtab][ridx] : '0;
endmodule

// File: rtl/dqz_mul.sv
module dqz_mul #(
   parameter int COEF_W = 11,
   parameter int QT_W   = 8,
   parameter int DQ_W   = 16,
   parameter bit SAT_EN = 1'b1
) (
   input  logic signed [COEF_W-1:0] coef,
   input  logic        [QT_W-1:0]   q,
   output logic signed [DQ_W-1:0]   dq
);
   localparam int P_W = COEF_W + QT_W + 1;
   localparam logic signed [P_W-1:0] MAXV = P_W'((2 ** (DQ_W - 1)) - 1);
   localparam logic signed [P_W-1:0] MINV = -P_W'(2 ** (DQ_W - 1));

   logic signed [P_W-1:0] prod;
   assign prod = P_W'(coef) * $signed({1'b0, q});

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            if (prod > MAXV)      dq = MAXV[DQ_W-1:0];
            else if (prod < MINV) dq = MINV[DQ_W-1:0];
            else                  dq = prod[DQ_W-1:0];
         end
      end else begin : g_wrap
         assign dq = prod[DQ_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/dqz_pix.sv
module dqz_pix #(
   parameter int DQ_W  = 16,
   parameter int PIX_W = 8,
   parameter int DOWN  = 8
) (
   input  logic signed [DQ_W-1:0]  dq,
   output logic        [PIX_W-1:0] pix
);
   localparam int SH  = $clog2(DOWN);
   localparam int MID = 2 ** (PIX_W - 1);
   localparam int TOP = (2 ** PIX_W) - 1;

   logic signed [DQ_W:0] sum;
   assign sum = (DQ_W + 1)'(dq >>> SH) + (DQ_W + 1)'(MID);

   always_comb begin
      if (sum < 0)              pix = '0;
      else if (sum > TOP)       pix = PIX_W'(TOP);
      else                      pix = sum[PIX_W-1:0];
   end
endmodule

// File: rtl/dqz_reorder.sv
module dqz_reorder #(
   parameter int COEF_W = 11,
   parameter int QT_W   = 8,
   parameter int DQ_W   = 16,
   parameter int NTAB   = 4,
   parameter int TSEL_W = 2,
   parameter int PIX_W  = 8,
   parameter int DOWN   = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [COEF_W-1:0]         in_coef,
   input  logic [TSEL_W-1:0]         tab_sel,
   input  logic                      scale_en,
   input  logic                      qt_we,
   input  logic [TSEL_W-1:0]         qt_tab,
   input  logic [dqz_pkg::IDX_W-1:0] qt_idx,
   input  logic [QT_W-1:0]           qt_val,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [DQ_W-1:0]           out_data,
   output logic                      out_last
);
   import dqz_pkg::*;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_N - 1);

   generate
      if (NTAB < 1 || NTAB > 2 ** TSEL_W) begin : g_bad_ntab
         $error("NTAB does not fit TSEL_W");
      end
      if (DQ_W < COEF_W || PIX_W > DQ_W) begin : g_bad_w
         $error("output width too small");
      end
      if (DOWN != 2 ** $clog2(DOWN)) begin : g_bad_down
         $error("DOWN must be a power of two");
      end
   endgenerate

   logic [IDX_W-1:0] zz_lut [BLK_N];
   generate
      for (genvar g = 0; g < BLK_N; g++) begin : g_lut
         assign zz_lut[g] = zz2nat(g);
      end
   endgenerate

   logic [DQ_W-1:0]   mem [2][BLK_N];
   logic [1:0]        full, scl;
   logic              wb, rb;
   logic [IDX_W-1:0]  wi, ri;
   logic [TSEL_W-1:0] sel_q;
   logic              scl_q;

   logic              acc, pop, blk_end;
   logic [TSEL_W-1:0] sel_eff;
   logic              scl_eff;
   logic [QT_W-1:0]   q;
   logic signed [DQ_W-1:0] dq;
   logic [PIX_W-1:0]  pix;
   logic [DQ_W-1:0]   wval;

   assign in_ready = !full[wb];
   assign acc      = in_valid && in_ready;
   assign sel_eff  = (wi == '0) ? tab_sel  : sel_q;
   assign scl_eff  = (wi == '0) ? scale_en : scl_q;
   assign blk_end  = acc && (wi == LAST_IDX);

   dqz_qtab #(.NTAB(NTAB), .TSEL_W(TSEL_W), .QT_W(QT_W)) u_qtab (
      .clk(clk), .rst_n(rst_n), .we(qt_we), .wtab(qt_tab), .widx(qt_idx),
      .wval(qt_val), .rtab(sel_eff), .ridx(wi), .rval(q));

   dqz_mul #(.COEF_W(COEF_W), .QT_W(QT_W), .DQ_W(DQ_W), .SAT_EN(SAT_EN)) u_mul (
      .coef(in_coef), .q(q), .dq(dq));

   dqz_pix #(.DQ_W(DQ_W), .PIX_W(PIX_W), .DOWN(DOWN)) u_pix (
      .dq(dq), .pix(pix));

   assign wval = (scl_eff && wi == '0) ? DQ_W'(pix) : dq;

   always_ff @(posedge clk) begin
      if (acc) mem[wb][zz_lut[wi]] <= wval;
   end

   assign out_valid = full[rb];
   assign out_data  = mem[rb][ri];
   assign out_last  = full[rb] && (scl[rb] || ri == LAST_IDX);
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full  <= '0;
         scl   <= '0;
         wb    <= 1'b0;
         rb    <= 1'b0;
         wi    <= '0;
         ri    <= '0;
         sel_q <= '0;
         scl_q <= 1'b0;
      end else begin
         if (acc) begin
            wi <= wi + 1'b1;
            if (wi == '0) begin
               sel_q <= tab_sel;
               scl_q <= scale_en;
            end
         end
         if (blk_end) begin
            full[wb] <= 1'b1;
            scl[wb]  <= scl_eff;
            wb       <= !wb;
         end
         if (pop) begin
            if (out_last) begin
               full[rb] <= 1'b0;
               rb       <= !rb;
               ri       <= '0;
            end else begin
               ri <= ri + 1'b1;
            end
         end
      end
   end

   // R9: a stalled word is held
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R6: downscale blocks give a single in-range pixel
   a_r6_pix_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && scl[rb] |-> out_last && (out_data[DQ_W-1:PIX_W] == '0));

   // R2: a zero coefficient dequantizes to zero
   a_r2_zero_prod: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_coef == '0 |-> dq == '0);

   // R4: clamping never flips the sign of a positive product
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !in_coef[COEF_W-1] && in_coef != '0 && q != '0 |-> dq > 0);

   // R8: never more than two blocks held, a full bank is not written
   a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      full == 2'b11 |-> !in_ready);
endmodule

// File: tb/test_dqz_reorder.sv
module test_dqz_reorder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [10:0] in_coef = '0;
   logic [1:0] tab_sel = '0;
   logic scale_en = 1'b0;
   logic qt_we = 1'b0;
   logic [1:0] qt_tab = '0;
   logic [5:0] qt_idx = '0;
   logic [7:0] qt_val = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [15:0] out_data;
   logic out_last;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int nat [64];
   int qm [4][64];
   int cf [64];

   always #2 clk = !clk;

   dqz_reorder i_dqz_reorder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_coef(in_coef), .tab_sel(tab_sel), .scale_en(scale_en),
      .qt_we(qt_we), .qt_tab(qt_tab), .qt_idx(qt_idx), .qt_val(qt_val),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog: act=timeout exp=finish");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int sat16(input int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic int pixel(input int d);
      int v;
      v = (d >>> 3) + 128;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      return v;
   endfunction

   task automatic build_zigzag();
      int r = 0, c = 0, up = 1;
      for (int k = 0; k < 64; k++) begin
         nat[k] = r * 8 + c;
         if (up == 1) begin
            if (c == 7) begin r++; up = 0; end
            else if (r == 0) begin c++; up = 0; end
            else begin r--; c++; end
         end else begin
            if (r == 7) begin c++; up = 1; end
            else if (c == 0) begin r++; up = 1; end
            else begin r++; c--; end
         end
      end
   endtask

   task automatic load(input int t, input int k, input int v);
      qt_we = 1'b1; qt_tab = 2'(t); qt_idx = 6'(k); qt_val = 8'(v);
      @(negedge clk);
      qt_we = 1'b0;
      qm[t][k] = v;
   endtask

   task automatic push(input int c);
      in_valid = 1'b1;
      in_coef = 11'(c);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send(input int sel, input int scl, input int sel2, input int scl2);
      for (int k = 0; k < 64; k++) begin
         tab_sel = 2'((k == 0) ? sel : sel2);
         scale_en = (k == 0) ? scl[0] : scl2[0];
         push(cf[k]);
      end
      in_valid = 1'b0;
   endtask

   task automatic pull(input string req, input int exp, input int last_exp);
      while (!out_valid) @(negedge clk);
      chk(req, int'($signed(out_data)), exp);
      chk({req, " last"}, int'(out_last), last_exp);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic drain_normal(input string req, input int t);
      int exp [64];
      for (int k = 0; k < 64; k++) exp[nat[k]] = sat16(cf[k] * qm[t][k]);
      for (int n = 0; n < 64; n++) pull(req, exp[n], (n == 63) ? 1 : 0);
   endtask

   task automatic t_reset();
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 in_ready", int'(in_ready), 1);
   endtask

   task automatic t_ramp_table1();
      for (int k = 0; k < 64; k++) load(1, k, (k % 7) + 1);
      for (int k = 0; k < 64; k++) cf[k] = k - 20;
      // R2 table switched after the first coefficient must be ignored
      send(1, 0, 3, 0);
      drain_normal("R2 R3 R5 R7 ramp", 1);
   endtask

   task automatic t_identity();
      for (int k = 0; k < 64; k++) cf[k] = 500 - 13 * k;
      send(0, 0, 0, 0);
      drain_normal("R1 R3 identity table", 0);
   endtask

   task automatic t_saturate();
      for (int k = 0; k < 64; k++) load(2, k, 255);
      for (int k = 0; k < 64; k++) cf[k] = (k % 3 == 0) ? 1023 : ((k % 3 == 1) ? -1024 : k);
      send(2, 0, 2, 0);
      drain_normal("R4 clamp", 2);
   endtask

   task automatic t_downscale();
      for (int k = 0; k < 64; k++) load(3, k, 2 + k);
      for (int k = 0; k < 64; k++) cf[k] = 7;
      cf[0] = 100; send(3, 1, 3, 1); pull("R6 mid", pixel(200), 1);
      cf[0] = -1024; send(2, 1, 2, 1); pull("R6 low clamp", 0, 1);
      cf[0] = 1023; send(2, 1, 2, 1); pull("R6 high clamp", 255, 1);
      cf[0] = -9; send(0, 1, 0, 1); pull("R6 floor", 126, 1);
      chk("R6 single word", int'(out_valid), 0);
   endtask

   task automatic t_mode_latch();
      for (int k = 0; k < 64; k++) cf[k] = k + 3;
      send(3, 1, 3, 0);
      pull("R10 scale kept", pixel(3 * 2), 1);
      chk("R10 no extra words", int'(out_valid), 0);
      send(1, 0, 1, 1);
      drain_normal("R10 normal kept", 1);
   endtask

   task automatic t_double_buffer();
      int held;
      int blk_a [64];
      for (int k = 0; k < 64; k++) cf[k] = k + 1;
      send(0, 0, 0, 0);
      blk_a = cf;
      for (int k = 0; k < 64; k++) cf[k] = -k;
      send(1, 0, 1, 0);
      in_valid = 1'b1; in_coef = 11'd5;
      held = int'($signed(out_data));
      for (int i = 0; i < 5; i++) begin
         chk("R8 third refused", int'(in_ready), 0);
         chk("R9 held valid", int'(out_valid), 1);
         chk("R9 held data", int'($signed(out_data)), held);
         @(negedge clk);
      end
      in_valid = 1'b0;
      chk("R9 first word", held, 1);
      for (int k = 0; k < 64; k++) begin
         int exp [64];
         for (int j = 0; j < 64; j++) exp[nat[j]] = blk_a[j];
         pull("R8 block A", exp[k], (k == 63) ? 1 : 0);
         if (k < 63) chk("R8 still stalled", int'(in_ready), 0);
      end
      chk("R8 freed", int'(in_ready), 1);
      drain_normal("R8 block B", 1);
   endtask

   initial begin
      build_zigzag();
      for (int t = 0; t < 4; t++) for (int k = 0; k < 64; k++) qm[t][k] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      chk("R3 zigzag 3", nat[3], 16);
      t_ramp_table1();
      t_identity();
      t_saturate();
      t_downscale();
      t_mode_latch();
      t_double_buffer();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule